// File: doc/BRIEF.md
# PCI Slot Hotplug Register Window

This block keeps the hotplug bookkeeping for up to 32 PCI slots behind a small 16-byte I/O window. System firmware reads and writes it. Three slot masks are held inside. The present mask marks slots that hold a device. The removable mask marks slots whose device may be hot-removed. The pending-removal mask marks slots for which removal has been requested but not yet confirmed by the guest.

Insert and remove events arrive on an event port together with a slot number. A coldplug qualifier marks inserts made while the machine is being built. Hot events raise a one-cycle pulse toward the general-purpose event block, where it drives status bit 1. The guest confirms a removal by writing a slot mask to the eject register. The block then emits a one-cycle eject strobe carrying the chosen slot number, so that the device teardown logic outside can act on it.

Removable and present state are rebuilt from two input masks during the first clock after reset is released. Those inputs describe the devices present at start-up and the slots that hold non-hotpluggable devices.

Top module: `hp_slot_window`

## Requirements
- R1: During the first clock after reset release the block loads present = `boot_present`, removable = NOT `fixed_slots`, pending = 0. Events and register writes presented in that clock are not applied. After it, offset 0x4 reads 0, offset 0xC reads NOT `fixed_slots`, and neither strobe is high.
- R2: A valid read of offset 0x0 returns (present AND removable), with zeros above slot NSLOT-1.
- R3: A valid read of offset 0x4 returns the pending-removal mask.
- R4: A valid read of offset 0x8 returns zero. A valid read of offset 0xC returns the removable mask.
- R5: A valid write to offset 0x8 with nonzero data picks the lowest set bit of the data as the slot and clears that slot's pending bit. In the cycle after the write, `eject_stb` is high for one cycle and `eject_slot` holds that bit's index.
- R6: An eject of a slot that is removable also clears its present bit, which is visible at offset 0x0. An eject of a non-removable slot leaves its present bit set.
- R7: A write to offset 0x8 with data zero has no effect and gives no strobe. Writes to offsets 0x0, 0x4 and 0xC change nothing.
- R8: A hot insert event (`evt_insert`=1, `evt_cold`=0) sets the slot's present bit. `gpe_pulse` is high for one cycle in the cycle after the event.
- R9: A remove event (`evt_insert`=0; `evt_cold` is ignored) sets the slot's pending bit and pulses `gpe_pulse` the same way.
- R10: A coldplug insert (`evt_insert`=1, `evt_cold`=1) sets the present bit and gives no `gpe_pulse`.
- R11: An access is valid only with `reg_be`=4'hF and `reg_addr[1:0]`=0. An invalid access writes nothing, gives no strobe, and reads back zero. Any read with `reg_sel` low also returns zero.
- R12: When an eject and an event fall in the same cycle, the eject is applied first and the event second. A remove event on the ejected slot therefore leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset inside the window |
| reg_be | input | 4 | Byte enables; only 4'hF is valid |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_valid | input | 1 | Slot event in this cycle |
| evt_insert | input | 1 | 1 = insert, 0 = remove request |
| evt_cold | input | 1 | Insert is a coldplug (no event raised) |
| evt_slot | input | 5 | Slot number of the event |
| boot_present | input | 32 | Slots holding a device at start-up |
| fixed_slots | input | 32 | Slots holding non-hotpluggable devices |
| gpe_pulse | output | 1 | One-cycle hotplug status pulse (status bit 1) |
| eject_stb | output | 1 | One-cycle eject strobe |
| eject_slot | output | 5 | Slot number carried by the eject strobe |

## Verification
The hardest case to reach is an eject write and a remove event that land in the same clock on the same slot. Only that collision shows the order in which the two updates are applied. The bench drives both on one falling edge after the slot has already been made pending. It then reads offsets 0x0 and 0x4 to see that the present bit was cleared while the pending bit stayed set. A fixed slot is also ejected. Its present bit cannot be seen through offset 0x0, so that case is checked through the strobe and the pending mask only.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned WIN_DW = 32;
  localparam int unsigned WIN_AW = 4;

  typedef enum logic [1:0] {
    RG_UP    = 2'd0,
    RG_DOWN  = 2'd1,
    RG_EJECT = 2'd2,
    RG_REMOV = 2'd3
  } hp_reg_e;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
  import hp_pkg::*;
#(
  parameter int unsigned NSLOT = 32
) (
  input  logic              rd_ok,
  input  hp_reg_e           sel,
  input  logic [NSLOT-1:0]  present,
  input  logic [NSLOT-1:0]  removable,
  input  logic [NSLOT-1:0]  pending,
  output logic [WIN_DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (sel)
        RG_UP:    rdata = WIN_DW'(present & removable);
        RG_DOWN:  rdata = WIN_DW'(pending);
        RG_EJECT: rdata = '0;
        RG_REMOV: rdata = WIN_DW'(removable);
      endcase
    end
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state #(
  parameter int unsigned NSLOT = 32,
  localparam int unsigned SW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             ej_fire,
  input  logic [SW-1:0]    ej_slot,
  input  logic             evt_valid,
  input  logic             evt_insert,
  input  logic             evt_cold,
  input  logic [SW-1:0]    evt_slot,
  input  logic [NSLOT-1:0] boot_present,
  input  logic [NSLOT-1:0] fixed_slots,
  output logic [NSLOT-1:0] present_q,
  output logic [NSLOT-1:0] removable_q,
  output logic [NSLOT-1:0] pending_q,
  output logic             gpe_q,
  output logic             ej_stb_q,
  output logic [SW-1:0]    ej_slot_q
);
  logic [NSLOT-1:0] present_d, removable_d, pending_d;
  logic             mask_en, gpe_d, ej_stb_d, slot_en;

  assign mask_en  = init | ej_fire | evt_valid;
  assign gpe_d    = ~init & evt_valid & ~(evt_insert & evt_cold);
  assign ej_stb_d = ~init & ej_fire;
  assign slot_en  = ej_stb_d;

  always_comb begin
    present_d   = present_q;
    removable_d = removable_q;
    pending_d   = pending_q;
    if (init) begin
      present_d   = boot_present;
      removable_d = ~fixed_slots;
      pending_d   = '0;
    end else begin
      if (ej_fire) begin
        pending_d[ej_slot] = 1'b0;
        if (removable_q[ej_slot]) present_d[ej_slot] = 1'b0;
      end
      if (evt_valid) begin
        if (evt_insert) present_d[evt_slot] = 1'b1;
        else            pending_d[evt_slot] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q   <= '0;
      removable_q <= '0;
      pending_q   <= '0;
      gpe_q       <= 1'b0;
      ej_stb_q    <= 1'b0;
      ej_slot_q   <= '0;
    end else begin
      gpe_q    <= gpe_d;
      ej_stb_q <= ej_stb_d;
      if (slot_en) ej_slot_q <= ej_slot;
      if (mask_en) begin
        present_q   <= present_d;
        removable_q <= removable_d;
        pending_q   <= pending_d;
      end
    end
  end
endmodule

// File: rtl/hp_slot_window.sv
module hp_slot_window
  import hp_pkg::*;
#(
  parameter int unsigned NSLOT = 32,
  localparam int unsigned SW   = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [WIN_DW-1:0] reg_wdata,
  output logic [WIN_DW-1:0] reg_rdata,
  input  logic              evt_valid,
  input  logic              evt_insert,
  input  logic              evt_cold,
  input  logic [SW-1:0]     evt_slot,
  input  logic [NSLOT-1:0]  boot_present,
  input  logic [NSLOT-1:0]  fixed_slots,
  output logic              gpe_pulse,
  output logic              eject_stb,
  output logic [SW-1:0]     eject_slot
);
  logic             init_q;
  logic             acc_ok, rd_ok, ej_wr, ej_any, ej_fire;
  logic [SW-1:0]    ej_idx;
  hp_reg_e          rsel;
  logic [NSLOT-1:0] present, removable, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= 1'b0;
  end

  assign acc_ok  = reg_sel & (reg_be == 4'hF) & (reg_addr[1:0] == 2'b00);
  assign rsel    = hp_reg_e'(reg_addr[3:2]);
  assign rd_ok   = acc_ok & ~reg_we;
  assign ej_wr   = acc_ok & reg_we & (rsel == RG_EJECT);
  assign ej_fire = ej_wr & ej_any;

  hp_lowbit #(.W(NSLOT)) u_lowbit (
    .vec (reg_wdata[NSLOT-1:0]),
    .any (ej_any),
    .idx (ej_idx)
  );

  hp_slot_state #(.NSLOT(NSLOT)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .init         (init_q),
    .ej_fire      (ej_fire),
    .ej_slot      (ej_idx),
    .evt_valid    (evt_valid),
    .evt_insert   (evt_insert),
    .evt_cold     (evt_cold),
    .evt_slot     (evt_slot),
    .boot_present (boot_present),
    .fixed_slots  (fixed_slots),
    .present_q    (present),
    .removable_q  (removable),
    .pending_q    (pending),
    .gpe_q        (gpe_pulse),
    .ej_stb_q     (eject_stb),
    .ej_slot_q    (eject_slot)
  );

  hp_read_mux #(.NSLOT(NSLOT)) u_rmux (
    .rd_ok     (rd_ok),
    .sel       (rsel),
    .present   (present),
    .removable (removable),
    .pending   (pending),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/hp_slot_window_chk.sv
module hp_slot_window_chk #(
  parameter int unsigned NSLOT = 32,
  localparam int unsigned SW   = $clog2(NSLOT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_q,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              evt_valid,
  input logic              evt_insert,
  input logic              evt_cold,
  input logic              gpe_pulse,
  input logic              eject_stb,
  input logic [SW-1:0]     eject_slot
);
  logic good, ej_req;
  assign good   = reg_sel && reg_be == 4'hF && reg_addr[1:0] == 2'b00;
  assign ej_req = good && reg_we && reg_addr[3:2] == 2'd2
                  && reg_wdata[NSLOT-1:0] != '0 && !init_q;

  // R5
  eject_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_req |=> eject_stb);

  // R7
  eject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ej_req |=> !eject_stb);

  // R8
  hot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !init_q && !(evt_insert && evt_cold)) |=> gpe_pulse);

  // R10
  cold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid || init_q || (evt_insert && evt_cold)) |=> !gpe_pulse);

  // R4
  feat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good && !reg_we && reg_addr[3:2] == 2'd2) |-> reg_rdata == 32'h0);

  // R11
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !good |-> reg_rdata == 32'h0);

  // R5
  eject_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ej_req |=> $stable(eject_slot));
endmodule

bind hp_slot_window hp_slot_window_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_q     (init_q),
  .reg_sel    (reg_sel),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_be     (reg_be),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .evt_valid  (evt_valid),
  .evt_insert (evt_insert),
  .evt_cold   (evt_cold),
  .gpe_pulse  (gpe_pulse),
  .eject_stb  (eject_stb),
  .eject_slot (eject_slot)
);

// File: tb/test_hp_slot_window.sv
`timescale 1ns/100ps
module test_hp_slot_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_we;
  logic [3:0]  reg_addr, reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        evt_valid, evt_insert, evt_cold;
  logic [4:0]  evt_slot;
  logic [31:0] boot_present, fixed_slots;
  logic        gpe_pulse, eject_stb;
  logic [4:0]  eject_slot;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hp_slot_window i_hp_slot_window (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_valid(evt_valid), .evt_insert(evt_insert),
    .evt_cold(evt_cold), .evt_slot(evt_slot), .boot_present(boot_present),
    .fixed_slots(fixed_slots), .gpe_pulse(gpe_pulse), .eject_stb(eject_stb),
    .eject_slot(eject_slot)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [3:0] be,
                    input logic [31:0] exp);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a; reg_be = be;
    #1 chk(req, reg_rdata, exp);
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  // write; check strobe and slot after the sampling edge
  task automatic wr(input string req, input logic [3:0] a, input logic [3:0] be,
                    input logic [31:0] d, input logic exp_stb, input logic [4:0] exp_slot);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(posedge clk); #1;
    chk(req, {31'b0, eject_stb}, {31'b0, exp_stb});
    if (exp_stb) chk(req, {27'b0, eject_slot}, {27'b0, exp_slot});
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
    @(posedge clk); #1;
    chk(req, {31'b0, eject_stb}, 32'h0);
  endtask

  task automatic ev(input string req, input logic [4:0] s, input logic ins,
                    input logic cold, input logic exp_pulse);
    @(negedge clk);
    evt_valid = 1'b1; evt_slot = s; evt_insert = ins; evt_cold = cold;
    @(posedge clk); #1;
    chk(req, {31'b0, gpe_pulse}, {31'b0, exp_pulse});
    @(negedge clk);
    evt_valid = 1'b0;
    @(posedge clk); #1;
    chk(req, {31'b0, gpe_pulse}, 32'h0);
  endtask

  task automatic t_reset();
    rd("R1", 4'h4, 4'hF, 32'h0);
    rd("R1", 4'hC, 4'hF, 32'hFFFF_FFFD);
    rd("R2", 4'h0, 4'hF, 32'h0000_0011);
    rd("R4", 4'h8, 4'hF, 32'h0);
    chk("R1", {30'b0, gpe_pulse, eject_stb}, 32'h0);
  endtask

  task automatic t_events();
    ev("R8", 5'd7, 1'b1, 1'b0, 1'b1);
    rd("R8", 4'h0, 4'hF, 32'h0000_0091);
    ev("R10", 5'd9, 1'b1, 1'b1, 1'b0);
    rd("R10", 4'h0, 4'hF, 32'h0000_0291);
    ev("R9", 5'd4, 1'b0, 1'b0, 1'b1);
    rd("R3", 4'h4, 4'hF, 32'h0000_0010);
    ev("R9", 5'd1, 1'b0, 1'b1, 1'b1);
    rd("R3", 4'h4, 4'hF, 32'h0000_0012);
  endtask

  task automatic t_eject();
    wr("R5", 4'h8, 4'hF, 32'h0000_0012, 1'b1, 5'd1);
    rd("R5", 4'h4, 4'hF, 32'h0000_0010);
    rd("R6", 4'h0, 4'hF, 32'h0000_0291);
    wr("R5", 4'h8, 4'hF, 32'hC000_0010, 1'b1, 5'd4);
    rd("R6", 4'h0, 4'hF, 32'h0000_0281);
    rd("R5", 4'h4, 4'hF, 32'h0);
  endtask

  task automatic t_ignored();
    ev("R9", 5'd0, 1'b0, 1'b0, 1'b1);
    wr("R7", 4'h8, 4'hF, 32'h0, 1'b0, 5'd0);
    wr("R7", 4'h0, 4'hF, 32'hFFFF_FFFF, 1'b0, 5'd0);
    wr("R7", 4'h4, 4'hF, 32'h0, 1'b0, 5'd0);
    wr("R7", 4'hC, 4'hF, 32'h0, 1'b0, 5'd0);
    rd("R7", 4'h4, 4'hF, 32'h0000_0001);
    rd("R7", 4'hC, 4'hF, 32'hFFFF_FFFD);
    rd("R7", 4'h0, 4'hF, 32'h0000_0281);
  endtask

  task automatic t_bad_access();
    wr("R11", 4'h8, 4'h3, 32'h0000_0001, 1'b0, 5'd0);
    wr("R11", 4'h9, 4'hF, 32'h0000_0001, 1'b0, 5'd0);
    rd("R11", 4'h4, 4'hF, 32'h0000_0001);
    rd("R11", 4'hC, 4'h3, 32'h0);
    rd("R11", 4'hD, 4'hF, 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 4'h8; reg_be = 4'hF;
    reg_wdata = 32'h0000_0001;
    evt_valid = 1'b1; evt_slot = 5'd0; evt_insert = 1'b0; evt_cold = 1'b0;
    @(posedge clk); #1;
    chk("R12", {31'b0, eject_stb}, 32'h1);
    chk("R12", {31'b0, gpe_pulse}, 32'h1);
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; evt_valid = 1'b0;
    rd("R12", 4'h4, 4'hF, 32'h0000_0001);
    rd("R12", 4'h0, 4'hF, 32'h0000_0280);
    wr("R12", 4'h8, 4'hF, 32'h0000_0001, 1'b1, 5'd0);
    rd("R12", 4'h4, 4'hF, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_be = '0;
    reg_wdata = '0; evt_valid = 1'b0; evt_insert = 1'b0; evt_cold = 1'b0;
    evt_slot = '0; boot_present = 32'h0000_0013; fixed_slots = 32'h0000_0002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: event offered in the initialisation clock must not apply
    evt_valid = 1'b1; evt_insert = 1'b1; evt_cold = 1'b0; evt_slot = 5'd20;
    @(posedge clk); #1;
    chk("R1", {31'b0, gpe_pulse}, 32'h0);
    @(negedge clk);
    evt_valid = 1'b0;
    t_reset();
    t_events();
    t_eject();
    t_ignored();
    t_bad_access();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule